// File: doc/BRIEF.md
# Ternary Longest-Prefix Route Table

This block is a small ternary match table for IPv4 route lookup. Each slot stores a 32-bit pattern, a 32-bit care mask and a next-hop index, plus a valid flag. On every clock cycle the search key is compared against all slots at once. A slot matches when it is valid and agrees with the key on every bit its mask marks as cared. Bits the mask clears are wildcards and always agree.

When several slots match, the slot with the lowest address wins. Software that loads the table must therefore place longer prefixes at lower addresses. A zero-mask default route placed in the last slot then catches every key that nothing else claims. Loading uses a single-slot write port. Search results come from a register stage, so each lookup has one cycle of latency.

Top module: `tcam_lpm`

## Requirements
- R1: A write with `wr_en` high stores `wr_pattern`, `wr_care`, `wr_nexthop` and `wr_valid` into slot `wr_slot` at the clock edge. A search whose key is presented in the following cycle sees the new contents.
- R2: A slot matches a key when, at every bit position where its care mask is 1, the key bit equals the stored pattern bit. Key bits where the care mask is 0 never prevent a match.
- R3: A slot whose valid flag is 0 never matches, whatever its mask and pattern hold.
- R4: When no slot matches, `hit` is 0 and `nexthop` is all zeros.
- R5: When two or more slots match, `nexthop` is the value stored in the matching slot with the lowest address.
- R6: The `hit` and `nexthop` values after a clock edge reflect the `key` sampled at that edge, against the table contents held before that edge. A new key can be presented every cycle.
- R7: When a write and a search fall in the same cycle, that search sees the table as it was before the write.
- R8: Synchronous reset (`rst` high) clears every valid flag and drives `hit` to 0 and `nexthop` to zero.
- R9: With a /24 route placed above an overlapping /16 route and a 0/0 route in the last slot, these outcomes hold. A key inside the /24 returns the /24 next hop. A key only inside the /16 returns the /16 next hop. Any other key returns the default next hop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one slot |
| wr_slot | input | SLOT_W (4) | Slot address to write |
| wr_pattern | input | KEY_W (32) | Pattern bits to store |
| wr_care | input | KEY_W (32) | Care mask, 1 = bit compared |
| wr_nexthop | input | RES_W (8) | Next-hop index to store |
| wr_valid | input | 1 | Valid flag to store |
| key | input | KEY_W (32) | Search key, compared every cycle |
| hit | output | 1 | Registered: some valid slot matched |
| nexthop | output | RES_W (8) | Registered: winning next hop, zero on miss |

## Verification
Both `hit` and `nexthop` are due one clock edge after the key is applied. The bench changes the key on a falling edge and reads the outputs on the next falling edge, after exactly one rising edge. A write is treated the same way: its effect is first expected from a key applied in the cycle after the write edge. When a write and a key share a cycle, the expected result is computed from the model as it stood before the write. A streaming pass applies a new key every cycle and compares each output against the key applied one cycle earlier.

// File: rtl/tcam_lpm_pkg.sv
package tcam_lpm_pkg;
   // priority encoder variants
   localparam int ENC_SCAN    = 0;   // loop from highest to lowest slot
   localparam int ENC_ISOLATE = 1;   // two's-complement lowest-bit isolate

   function automatic int slot_bits(input int depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/tcam_slot_array.sv
module tcam_slot_array
   import tcam_lpm_pkg::*;
#(
   parameter int KEY_W = 32,
   parameter int RES_W = 8,
   parameter int DEPTH = 16,
   localparam int SLOT_W = slot_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [KEY_W-1:0]  wr_pattern,
   input  logic [KEY_W-1:0]  wr_care,
   input  logic [RES_W-1:0]  wr_nexthop,
   input  logic              wr_valid,
   input  logic [KEY_W-1:0]  key,
   output logic [DEPTH-1:0]  match,
   output logic [RES_W-1:0]  slot_res [DEPTH]
);
   logic [KEY_W-1:0] pat_q  [DEPTH];
   logic [KEY_W-1:0] care_q [DEPTH];
   logic [RES_W-1:0] res_q  [DEPTH];
   logic [DEPTH-1:0] vld_q;

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_slot == SLOT_W'(s));

      always_ff @(posedge clk) begin
         if (rst) begin
            pat_q[s]  <= '0;
            care_q[s] <= '0;
            res_q[s]  <= '0;
            vld_q[s]  <= 1'b0;
         end else if (sel) begin
            pat_q[s]  <= wr_pattern;
            care_q[s] <= wr_care;
            res_q[s]  <= wr_nexthop;
            vld_q[s]  <= wr_valid;
         end
      end

      assign match[s]    = vld_q[s] && (((key ^ pat_q[s]) & care_q[s]) == '0);
      assign slot_res[s] = res_q[s];
   end

   // R1: a completed write is found in the addressed slot one edge later
   assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en) && !$past(rst)) |->
         (vld_q[$past(wr_slot)] == $past(wr_valid) &&
          pat_q[$past(wr_slot)] == $past(wr_pattern) &&
          res_q[$past(wr_slot)] == $past(wr_nexthop)));
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc
   import tcam_lpm_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int ENC_STYLE = ENC_ISOLATE
) (
   input  logic [DEPTH-1:0] req,
   output logic [DEPTH-1:0] grant,
   output logic             any
);
   localparam logic [DEPTH-1:0] ONE = {{(DEPTH-1){1'b0}}, 1'b1};

   if (ENC_STYLE == ENC_SCAN) begin : g_scan
      always_comb begin
         grant = '0;
         for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) grant = ONE << i;
         end
      end
   end else if (ENC_STYLE == ENC_ISOLATE) begin : g_isolate
      assign grant = req & (~req + ONE);
   end else begin : g_bad
      $error("tcam_prio_enc: unknown ENC_STYLE");
   end

   assign any = |req;

   // R5: exactly the lowest requesting slot is granted
   always_comb begin
      if (!$isunknown(req)) begin
         assert_lowest_wins_R5: assert ($onehot0(grant) &&
                                        (((grant - ONE) & req) == '0) &&
                                        ((grant & req) == grant));
      end
   end
endmodule

// File: rtl/tcam_lpm.sv
module tcam_lpm
   import tcam_lpm_pkg::*;
#(
   parameter int KEY_W     = 32,
   parameter int RES_W     = 8,
   parameter int DEPTH     = 16,
   parameter int ENC_STYLE = ENC_ISOLATE,
   localparam int SLOT_W   = slot_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [KEY_W-1:0]  wr_pattern,
   input  logic [KEY_W-1:0]  wr_care,
   input  logic [RES_W-1:0]  wr_nexthop,
   input  logic              wr_valid,
   input  logic [KEY_W-1:0]  key,
   output logic              hit,
   output logic [RES_W-1:0]  nexthop
);
   if (DEPTH < 2)  begin : g_chk_depth $error("tcam_lpm: DEPTH must be at least 2"); end
   if (KEY_W < 1)  begin : g_chk_key   $error("tcam_lpm: KEY_W must be positive"); end
   if (RES_W < 1)  begin : g_chk_res   $error("tcam_lpm: RES_W must be positive"); end

   logic [DEPTH-1:0] match;
   logic [DEPTH-1:0] grant;
   logic             any;
   logic [RES_W-1:0] slot_res [DEPTH];
   logic [RES_W-1:0] win_res;

   tcam_slot_array #(.KEY_W(KEY_W), .RES_W(RES_W), .DEPTH(DEPTH)) u_slots (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_pattern(wr_pattern),
      .wr_care(wr_care), .wr_nexthop(wr_nexthop), .wr_valid(wr_valid),
      .key(key), .match(match), .slot_res(slot_res)
   );

   tcam_prio_enc #(.DEPTH(DEPTH), .ENC_STYLE(ENC_STYLE)) u_prio (
      .req(match), .grant(grant), .any(any)
   );

   // one-hot OR mux: zero when nothing is granted
   always_comb begin
      win_res = '0;
      for (int s = 0; s < DEPTH; s++) begin
         win_res |= slot_res[s] & {RES_W{grant[s]}};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hit     <= 1'b0;
         nexthop <= '0;
      end else begin
         hit     <= any;
         nexthop <= win_res;
      end
   end

   // R4: a miss never carries a stale next hop
   assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
      !hit |-> (nexthop == '0));

   // R3/R6: a hit is only reported when the slot array flagged a match one cycle earlier
   assert_hit_needs_match_R3: assert property (@(posedge clk) disable iff (rst)
      hit |-> $past(|match));

   // R8: the cycle after reset the outputs are idle
   assert_reset_clears_R8: assert property (@(posedge clk)
      $past(rst) |-> (!hit && nexthop == '0));
endmodule

// File: tb/tcam_lpm_tb.sv
module tcam_lpm_tb;
   localparam int KEY_W = 32;
   localparam int RES_W = 8;
   localparam int DEPTH = 16;
   localparam int SLOT_W = 4;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wr_en = 1'b0;
   logic [SLOT_W-1:0] wr_slot = '0;
   logic [KEY_W-1:0]  wr_pattern = '0;
   logic [KEY_W-1:0]  wr_care = '0;
   logic [RES_W-1:0]  wr_nexthop = '0;
   logic              wr_valid = 1'b0;
   logic [KEY_W-1:0]  key = '0;
   logic              hit;
   logic [RES_W-1:0]  nexthop;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   // reference table
   logic [KEY_W-1:0] m_pat  [DEPTH];
   logic [KEY_W-1:0] m_care [DEPTH];
   logic [RES_W-1:0] m_res  [DEPTH];
   logic             m_vld  [DEPTH];

   always #5 clk = ~clk;

   tcam_lpm #(.KEY_W(KEY_W), .RES_W(RES_W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
      .wr_pattern(wr_pattern), .wr_care(wr_care), .wr_nexthop(wr_nexthop),
      .wr_valid(wr_valid), .key(key), .hit(hit), .nexthop(nexthop)
   );

   function automatic logic [KEY_W-1:0] pfx(input int len);
      return (len == 0) ? '0 : ({KEY_W{1'b1}} << (KEY_W - len));
   endfunction

   function automatic logic [RES_W:0] model(input logic [KEY_W-1:0] k);
      for (int s = 0; s < DEPTH; s++) begin
         if (m_vld[s] && (((k ^ m_pat[s]) & m_care[s]) == '0)) return {1'b1, m_res[s]};
      end
      return '0;
   endfunction

   task automatic clear_model();
      for (int s = 0; s < DEPTH; s++) begin
         m_pat[s] = '0; m_care[s] = '0; m_res[s] = '0; m_vld[s] = 1'b0;
      end
   endtask

   task automatic compare(input logic [RES_W:0] exp, input string req);
      vectors++;
      if (hit !== exp[RES_W] || nexthop !== exp[RES_W-1:0]) begin
         errors++;
         $display("FAIL %s: hit=%0b nexthop=%0d expected hit=%0b nexthop=%0d",
                  req, hit, nexthop, exp[RES_W], exp[RES_W-1:0]);
      end
   endtask

   task automatic put(input int s, input logic [KEY_W-1:0] p, input logic [KEY_W-1:0] c,
                      input logic [RES_W-1:0] r, input logic v);
      @(negedge clk);
      wr_en = 1'b1; wr_slot = SLOT_W'(s); wr_pattern = p; wr_care = c;
      wr_nexthop = r; wr_valid = v;
      @(negedge clk);
      wr_en = 1'b0;
      m_pat[s] = p; m_care[s] = c; m_res[s] = r; m_vld[s] = v;
   endtask

   task automatic look(input logic [KEY_W-1:0] k, input string req);
      logic [RES_W:0] exp;
      @(negedge clk);
      key = k;
      exp = model(k);
      @(negedge clk);
      compare(exp, req);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      clear_model();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: hit=%0b nexthop=%0d expected hit=1 nexthop=0", hit, nexthop);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      logic [RES_W:0] exp_prev;
      clear_model();
      do_reset();

      // R8: idle outputs, empty table misses
      compare('0, "R8 reset outputs");
      look(32'h0000_0000, "R8 empty table");
      look(32'hFFFF_FFFF, "R8 empty table");

      // R2: single cared bit sweep over every position and both polarities
      for (int b = 0; b < KEY_W; b++) begin
         for (int pol = 0; pol < 2; pol++) begin
            logic [KEY_W-1:0] c, p;
            c = 32'h1 << b;
            p = pol[0] ? c : '0;
            put(0, p, c, RES_W'(b + 1), 1'b1);
            look((32'hA5C3_3C5A & ~c) | p, "R2 cared bit equal");
            look((32'h5A3C_C3A5 & ~c) | (~p & c), "R2 cared bit differs R4");
         end
      end

      // R2: zero mask matches anything
      put(0, 32'hDEAD_BEEF, '0, 8'd77, 1'b1);
      look(32'h0123_4567, "R2 all wildcards");

      // R3: invalid slot never matches
      put(0, 32'h0, '0, 8'd55, 1'b0);
      look(32'h1234_5678, "R3 invalid slot R4");

      // R9: overlapping routes with default last
      put(0, 32'h8002_9900, pfx(24), 8'd24, 1'b1);
      put(1, 32'h8002_0000, pfx(16), 8'd16, 1'b1);
      put(2, 32'h0A00_0000, pfx(8),  8'd10, 1'b1);
      put(DEPTH-1, 32'h0, pfx(0), 8'd99, 1'b1);
      look(32'h8002_9907, "R9 /24 wins over /16");
      look(32'h8002_0701, "R9 /16 only");
      look(32'h0A01_0203, "R9 /8");
      look(32'hC0A8_0001, "R9 default route");

      // R5: identical slots, lowest address wins; then fall back
      put(3, 32'hAC10_0000, pfx(12), 8'd33, 1'b1);
      put(5, 32'hAC10_0000, pfx(12), 8'd55, 1'b1);
      look(32'hAC1F_0001, "R5 lower slot wins");
      put(3, 32'hAC10_0000, pfx(12), 8'd33, 1'b0);
      look(32'hAC1F_0001, "R5 next slot after invalidation");

      // R1: write then search in the next cycle
      @(negedge clk);
      wr_en = 1'b1; wr_slot = 4'd4; wr_pattern = 32'hAC1F_0000; wr_care = pfx(16);
      wr_nexthop = 8'd44; wr_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      m_pat[4] = 32'hAC1F_0000; m_care[4] = pfx(16); m_res[4] = 8'd44; m_vld[4] = 1'b1;
      key = 32'hAC1F_0001;
      exp_prev = model(key);
      @(negedge clk);
      compare(exp_prev, "R1 new slot visible next cycle");

      // R7: write and search in the same cycle see old contents
      @(negedge clk);
      key = 32'h0B00_0001;
      exp_prev = model(key);                       // default route, 99
      wr_en = 1'b1; wr_slot = 4'd6; wr_pattern = 32'h0B00_0000; wr_care = pfx(8);
      wr_nexthop = 8'd11; wr_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      compare(exp_prev, "R7 same-cycle write not seen");
      m_pat[6] = 32'h0B00_0000; m_care[6] = pfx(8); m_res[6] = 8'd11; m_vld[6] = 1'b1;
      look(32'h0B00_0001, "R7 write seen afterwards");

      // R6: back-to-back keys, each result one cycle later
      @(negedge clk);
      key = 32'h8002_9901;
      exp_prev = model(key);
      for (int i = 0; i < 40; i++) begin
         logic [KEY_W-1:0] k;
         k = (i % 4 == 0) ? 32'h8002_9900 + KEY_W'(i) :
             (i % 4 == 1) ? 32'h8002_1000 + KEY_W'(i) :
             (i % 4 == 2) ? 32'hAC1F_0000 + KEY_W'(i) : 32'h7000_0000 + KEY_W'(i);
         @(negedge clk);
         compare(exp_prev, "R6 streamed lookup");
         key = k;
         exp_prev = model(k);
      end
      @(negedge clk);
      compare(exp_prev, "R6 streamed lookup");

      // R8: reset drops every slot
      do_reset();
      compare('0, "R8 outputs after reset");
      look(32'h8002_9907, "R8 table cleared");

      // R4 and R5: every slot holds an exact host route, swept in turn
      for (int s = 0; s < DEPTH; s++) put(s, 32'h0100_0000 + KEY_W'(s % 8), '1, RES_W'(s + 100), 1'b1);
      for (int s = 0; s < 10; s++) look(32'h0100_0000 + KEY_W'(s), "R5 duplicate host routes R4");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule